// File: doc/BRIEF.md
# In-band interrupt payload slice packer

This block gathers the payload bytes of an accepted in-band interrupt and turns them into a stream of 32-bit words in a queue that the host drains. The bytes arrive one per cycle on a push interface and wait in an internal byte staging buffer. A one-cycle finish pulse carries the requester's 7-bit address, its read/write bit and two flags: whether the interrupt was refused, and whether refused interrupts are still reported. On that pulse the block cuts the staged payload into slices of a programmable size. It writes one header word per slice into the queue, and the slice's bytes follow the header as little-endian data words.

The host reads the queue through a strobe. The word at the head is always visible on the read data port, and each strobe pops it. The block also outputs the queue level and the number of header words written for the most recent interrupt. It raises a threshold interrupt flag when the level crosses a programmable mark. Each enable gates the flag on its own: one gates the interrupt pin, the other gates the status view.

Top module: `ibi_slice_packer`

## Requirements
- R1: The slice size in bytes is four times the data-threshold field, and a field of 0 counts as 1, so the smallest slice is 4 bytes.
- R2: A computed slice size of 64 bytes or more is reduced to 63 bytes.
- R3: A header word has the last-slice flag in bit 31, the refused-status bit in bit 30, bits 29:16 zero, the ID in bits 15:8 and the slice byte count in bits 7:0. The ID is the 7-bit address shifted left by one, ORed with the read/write bit.
- R4: The payload is split into ceil(bytes / slice size) slices. Each slice except the last reports the slice size. The last slice reports the bytes that remain and sets the last-slice flag. No byte is lost.
- R5: An interrupt with no staged bytes writes exactly one header with length 0 and the last-slice flag set.
- R6: Data words follow their header. The first byte of a slice sits in bits 7:0 and later bytes fill upward. A word is written once it holds 4 bytes or the slice ends, and unused upper bytes are zero.
- R7: A refused interrupt with reporting off writes nothing, discards the staged bytes and leaves busy low. A refused interrupt with reporting on is written with bit 30 set.
- R8: After packing, the status-count output equals the number of header words written for that interrupt. A discarded interrupt leaves it unchanged.
- R9: The level output counts the words held. A read strobe on a non-empty queue pops the head and lowers the level by one. While the queue is empty the read data is 0, and a strobe has no effect.
- R10: The threshold is the status-threshold field plus 1. A write that leaves the level at or above it sets the threshold flag. A read that leaves the level below it clears the flag.
- R11: The interrupt output is the threshold flag ANDed with the signal enable. The status view is the flag ANDed with the status enable.
- R12: Busy is high from the cycle after an accepted finish pulse until the last word is written. The byte interface is not ready while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Payload byte offered |
| byte_data | input | 8 | Payload byte |
| byte_ready | output | 1 | Byte accepted when valid and ready |
| finish | input | 1 | One-cycle end-of-interrupt pulse |
| ibi_addr | input | 7 | Requester address |
| ibi_rnw | input | 1 | Requester read/write bit |
| nacked | input | 1 | Interrupt was refused |
| notify | input | 1 | Report refused interrupts |
| data_thld | input | DTW | Slice size field, in 4-byte units |
| stat_thld | input | STW | Queue threshold field (threshold minus 1) |
| rd_strobe | input | 1 | Pop the head word |
| rd_data | output | 32 | Head word, 0 when empty |
| level | output | LW | Words in the queue |
| status_cnt | output | SW | Headers written for the latest interrupt |
| sig_en | input | 1 | Interrupt pin enable |
| stat_en | input | 1 | Status view enable |
| irq | output | 1 | Interrupt output |
| stat_view | output | 1 | Gated threshold status |
| busy | output | 1 | Packing in progress |

## Verification
A wrong slice counter or byte-lane counter shows up as a misplaced or shifted byte in the word stream. It surfaces at the first read of the affected slice, a few cycles after the finish pulse. A wrong remainder count changes the length field or the last-slice flag of a header, and it also changes the status count that can be read as soon as busy falls. Level or threshold faults appear on the level, status-view and interrupt outputs in the cycle after the offending write or read, so the bench checks those outputs right after single reads.

// File: rtl/ibi_slice_packer.sv
module ibi_slice_packer #(
  parameter int STG_DEPTH = 64,
  parameter int Q_DEPTH   = 32,
  parameter int DTW       = 6,
  parameter int STW       = 5,
  parameter int LW        = $clog2(Q_DEPTH + 1),
  parameter int SW        = $clog2(STG_DEPTH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           byte_valid,
  input  logic [7:0]     byte_data,
  output logic           byte_ready,
  input  logic           finish,
  input  logic [6:0]     ibi_addr,
  input  logic           ibi_rnw,
  input  logic           nacked,
  input  logic           notify,
  input  logic [DTW-1:0] data_thld,
  input  logic [STW-1:0] stat_thld,
  input  logic           rd_strobe,
  output logic [31:0]    rd_data,
  output logic [LW-1:0]  level,
  output logic [SW-1:0]  status_cnt,
  input  logic           sig_en,
  input  logic           stat_en,
  output logic           irq,
  output logic           stat_view,
  output logic           busy
);

  localparam int SPW = $clog2(STG_DEPTH);
  localparam int CW  = $clog2(STG_DEPTH + 1);
  localparam int QPW = $clog2(Q_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA} st_t;
  st_t st;

  logic [7:0]     stg_mem [STG_DEPTH];
  logic [SPW-1:0] s_wp, s_rp;
  logic [CW-1:0]  s_cnt;
  logic [31:0]    q_mem [Q_DEPTH];
  logic [QPW-1:0] q_wp, q_rp;
  logic [LW-1:0]  lvl_n;
  logic           thr_flag;
  logic [31:0]    thr;

  logic [7:0]     id_r;
  logic           nk_r;
  logic [5:0]     slc_r, seg_r;
  logic [CW-1:0]  rem_r;
  logic [1:0]     lane_r;
  logic [31:0]    word_r;

  logic           drop, start, s_push, s_pop, q_full, q_push, q_pop;
  logic [DTW-1:0] dt_eff;
  logic [DTW+1:0] raw_sz;
  logic [5:0]     slc, seg_len;
  logic           last, data_end;
  logic [7:0]     byte_in;
  logic [31:0]    hdr_word, word_mix, q_wdata;

  assign busy       = (st != S_IDLE);
  assign drop       = finish && !busy && nacked && !notify;
  assign start      = finish && !busy && !drop;
  assign byte_ready = !busy && !finish && (s_cnt != CW'(STG_DEPTH));
  assign s_push     = byte_valid && byte_ready;
  assign q_full     = (level == LW'(Q_DEPTH));
  assign s_pop      = (st == S_DATA) && !q_full;
  assign q_pop      = rd_strobe && (level != '0);

  assign dt_eff = (data_thld == '0) ? DTW'(1) : data_thld;
  assign raw_sz = {dt_eff, 2'b00};
  assign slc    = (32'(raw_sz) >= 32'd64) ? 6'd63 : 6'(raw_sz);

  assign last     = (rem_r <= CW'(slc_r));
  assign seg_len  = last ? 6'(rem_r) : slc_r;
  assign hdr_word = {last, nk_r, 14'b0, id_r, 2'b00, seg_len};
  assign byte_in  = stg_mem[s_rp];
  assign word_mix = word_r | (32'(byte_in) << {lane_r, 3'b000});
  assign data_end = (lane_r == 2'd3) || (seg_r == 6'd1);

  always_comb begin
    q_push  = 1'b0;
    q_wdata = hdr_word;
    if (st == S_HDR && !q_full) begin
      q_push = 1'b1;
    end else if (st == S_DATA && !q_full && data_end) begin
      q_push  = 1'b1;
      q_wdata = word_mix;
    end
  end

  always_ff @(posedge clk)
    if (s_push) stg_mem[s_wp] <= byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_wp  <= '0;
      s_rp  <= '0;
      s_cnt <= '0;
    end else begin
      if (s_push) s_wp <= s_wp + 1'b1;
      if (drop) begin
        s_rp  <= s_wp;
        s_cnt <= '0;
      end else begin
        if (s_pop) s_rp <= s_rp + 1'b1;
        s_cnt <= s_cnt + CW'(s_push) - CW'(s_pop);
      end
    end
  end

  always_ff @(posedge clk)
    if (q_push) q_mem[q_wp] <= q_wdata;

  assign rd_data = (level != '0) ? q_mem[q_rp] : 32'h0;
  assign lvl_n   = level + LW'(q_push) - LW'(q_pop);
  assign thr     = 32'(stat_thld) + 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wp     <= '0;
      q_rp     <= '0;
      level    <= '0;
      thr_flag <= 1'b0;
    end else begin
      if (q_push) q_wp <= q_wp + 1'b1;
      if (q_pop)  q_rp <= q_rp + 1'b1;
      level <= lvl_n;
      if (q_push && 32'(lvl_n) >= thr)     thr_flag <= 1'b1;
      else if (q_pop && 32'(lvl_n) < thr) thr_flag <= 1'b0;
    end
  end

  assign irq       = sig_en & thr_flag;
  assign stat_view = stat_en & thr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      id_r       <= '0;
      nk_r       <= 1'b0;
      slc_r      <= '0;
      seg_r      <= '0;
      rem_r      <= '0;
      lane_r     <= '0;
      word_r     <= '0;
      status_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          id_r       <= {ibi_addr, ibi_rnw};
          nk_r       <= nacked;
          slc_r      <= slc;
          rem_r      <= s_cnt;
          status_cnt <= '0;
          st         <= S_HDR;
        end
        S_HDR: if (!q_full) begin
          status_cnt <= status_cnt + 1'b1;
          seg_r      <= seg_len;
          lane_r     <= '0;
          word_r     <= '0;
          st         <= (rem_r == '0) ? S_IDLE : S_DATA;
        end
        S_DATA: if (!q_full) begin
          rem_r <= rem_r - 1'b1;
          seg_r <= seg_r - 1'b1;
          if (data_end) begin
            word_r <= '0;
            lane_r <= '0;
          end else begin
            word_r <= word_mix;
            lane_r <= lane_r + 1'b1;
          end
          if (seg_r == 6'd1) st <= (rem_r == CW'(1)) ? S_IDLE : S_HDR;
        end
        default: st <= S_IDLE;
      endcase
      if (st == S_IDLE && !start) begin
        id_r <= '0;
        nk_r <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ibi_slice_packer_chk.sv
module ibi_slice_packer_chk #(
  parameter int Q_DEPTH = 32,
  parameter int STW     = 5,
  parameter int LW      = 6,
  parameter int SW      = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           finish,
  input logic           nacked,
  input logic           notify,
  input logic           busy,
  input logic           rd_strobe,
  input logic [LW-1:0]  level,
  input logic [SW-1:0]  status_cnt,
  input logic [STW-1:0] stat_thld,
  input logic           thr_flag
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= Q_DEPTH); // R9

  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && level == '0 && !busy |=> level == '0); // R9

  AST_READ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && level != '0 && !busy |=> level == $past(level) - LW'(1)); // R9

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && finish && nacked && !notify && !rd_strobe |=> !busy && $stable(level)); // R7

  AST_THLD_SET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_flag) |-> 32'(level) >= 32'($past(stat_thld)) + 32'd1); // R10

  AST_THLD_CLR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(thr_flag) |-> 32'(level) < 32'($past(stat_thld)) + 32'd1); // R10

  AST_DONE_HAS_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> status_cnt != '0); // R8

endmodule

bind ibi_slice_packer ibi_slice_packer_chk #(
  .Q_DEPTH(Q_DEPTH), .STW(STW), .LW(LW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .finish(finish), .nacked(nacked), .notify(notify),
  .busy(busy), .rd_strobe(rd_strobe), .level(level), .status_cnt(status_cnt),
  .stat_thld(stat_thld), .thr_flag(thr_flag)
);

// File: tb/test_ibi_slice_packer.sv
`timescale 1ns/1ps
module test_ibi_slice_packer;
  localparam int LW = 6;
  localparam int SW = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_ready;
  logic        finish = 1'b0;
  logic [6:0]  ibi_addr = '0;
  logic        ibi_rnw = 1'b0;
  logic        nacked = 1'b0;
  logic        notify = 1'b0;
  logic [5:0]  data_thld = '0;
  logic [4:0]  stat_thld = 5'd31;
  logic        rd_strobe = 1'b0;
  logic [31:0] rd_data;
  logic [LW-1:0] level;
  logic [SW-1:0] status_cnt;
  logic        sig_en = 1'b1;
  logic        stat_en = 1'b1;
  logic        irq, stat_view, busy;

  always #2.5 clk = ~clk;

  ibi_slice_packer i_ibi_slice_packer (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .finish(finish), .ibi_addr(ibi_addr), .ibi_rnw(ibi_rnw),
    .nacked(nacked), .notify(notify), .data_thld(data_thld), .stat_thld(stat_thld),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .level(level), .status_cnt(status_cnt),
    .sig_en(sig_en), .stat_en(stat_en), .irq(irq), .stat_view(stat_view), .busy(busy)
  );

  int n_chk = 0, n_bad = 0, exp_hdrs = 0;
  bit done = 1'b0, mon_en = 1'b1, man_rd = 1'b0;
  logic [31:0] exp_q[$];
  logic [7:0]  pl[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops words as they appear and compares against the scoreboard
  initial forever begin
    logic [31:0] e;
    @(posedge clk); #1;
    if (man_rd && level == '0) begin
      chk(rd_data == 32'h0, "R9 empty read data", rd_data, 32'h0);
      rd_strobe = 1'b1;
      man_rd = 1'b0;
    end else if ((mon_en || man_rd) && level != '0) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 surplus word", rd_data, 32'h0);
      else begin
        e = exp_q.pop_front();
        chk(rd_data == e, "R3 R4 R6 queue word", rd_data, e);
      end
      rd_strobe = 1'b1;
      man_rd = 1'b0;
    end else rd_strobe = 1'b0;
  end

  task automatic expect_ibi(input logic [7:0] id, input bit nk, input int dt);
    int slc = ((dt == 0) ? 1 : dt) * 4;
    int rem = pl.size();
    int k = 0;
    if (slc >= 64) slc = 63;
    exp_hdrs = 0;
    if (rem == 0) begin
      exp_q.push_back({1'b1, nk, 14'b0, id, 8'd0});
      exp_hdrs = 1;
    end
    while (rem > 0) begin
      int len;
      len = (rem <= slc) ? rem : slc;
      exp_q.push_back({rem <= slc, nk, 14'b0, id, 8'(len)});
      exp_hdrs++;
      for (int w = 0; w < (len + 3) / 4; w++) begin
        logic [31:0] wd;
        wd = '0;
        for (int b = 0; b < 4; b++)
          if (w * 4 + b < len) wd[8*b +: 8] = pl[k + w*4 + b];
        exp_q.push_back(wd);
      end
      k += len;
      rem -= len;
    end
  endtask

  task automatic run_ibi(input logic [6:0] a, input bit rnw, input bit nk, input bit nt, input int dt);
    data_thld = 6'(dt);
    for (int i = 0; i < pl.size(); i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data = pl[i];
    end
    @(negedge clk);
    byte_valid = 1'b0;
    ibi_addr = a; ibi_rnw = rnw; nacked = nk; notify = nt;
    if (!(nk && !nt)) expect_ibi({a, rnw}, nk, dt);
    finish = 1'b1;
    @(negedge clk);
    finish = 1'b0;
    if (!(nk && !nt))
      chk(busy && !byte_ready, "R12 busy blocks bytes", {30'b0, busy, byte_ready}, 32'h2);
    while (busy) @(negedge clk);
    nacked = 1'b0; notify = 1'b0;
    pl.delete();
  endtask

  task automatic drain();
    while (level != '0 || rd_strobe) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
  endtask

  task automatic man_read();
    man_rd = 1'b1;
    while (man_rd) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level == '0, "R9 reset level", 32'(level), 0);
    chk(status_cnt == '0, "R8 reset count", 32'(status_cnt), 0);
    chk(!busy && byte_ready, "R12 reset idle", {30'b0, busy, byte_ready}, 32'h1);
    chk(!irq && !stat_view, "R11 reset irq", {30'b0, irq, stat_view}, 0);
    chk(rd_data == 32'h0, "R9 reset read data", rd_data, 0);

    // R5: empty payload
    run_ibi(7'h2A, 1'b1, 1'b0, 1'b0, 0);
    chk(status_cnt == 1, "R5 lone header count", 32'(status_cnt), 1);
    drain();

    // R1: field 0 gives 4-byte slices, 10 bytes -> 3 headers
    for (int i = 0; i < 10; i++) pl.push_back(8'(i * 7 + 3));
    run_ibi(7'h11, 1'b0, 1'b0, 1'b0, 0);
    chk(status_cnt == 3, "R1 R8 slice count", 32'(status_cnt), 3);
    drain();

    // R4: exact multiple gives one last slice
    for (int i = 0; i < 8; i++) pl.push_back(8'(8'hA0 + i));
    run_ibi(7'h05, 1'b1, 1'b0, 1'b0, 2);
    chk(status_cnt == 1, "R4 exact slice count", 32'(status_cnt), 1);
    drain();

    // R2: 64-byte slice reduced to 63, padded last word (R6)
    for (int i = 0; i < 64; i++) pl.push_back(8'(i * 13 + 1));
    run_ibi(7'h7F, 1'b0, 1'b0, 1'b0, 16);
    chk(status_cnt == 2, "R2 clamped slice count", 32'(status_cnt), 2);
    drain();

    // R7: refused but reported sets bit 30
    for (int i = 0; i < 7; i++) pl.push_back(8'(8'h50 + i));
    run_ibi(7'h33, 1'b0, 1'b1, 1'b1, 1);
    chk(status_cnt == 2, "R7 reported refusal count", 32'(status_cnt), 2);
    drain();

    // R7: refused and unreported is discarded
    for (int i = 0; i < 5; i++) pl.push_back(8'(8'hE0 + i));
    run_ibi(7'h44, 1'b1, 1'b1, 1'b0, 0);
    @(negedge clk);
    chk(!busy && level == '0, "R7 discard no words", {25'b0, busy, level}, 0);
    chk(status_cnt == 2, "R8 discard keeps count", 32'(status_cnt), 2);
    run_ibi(7'h44, 1'b1, 1'b0, 1'b0, 0);
    chk(status_cnt == 1, "R7 staged bytes discarded", 32'(status_cnt), 1);
    drain();

    // R10 / R11: threshold behaviour with the monitor paused
    mon_en = 1'b0;
    stat_thld = 5'd2;
    for (int i = 0; i < 8; i++) pl.push_back(8'(8'h30 + i));
    run_ibi(7'h22, 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    chk(level == 4, "R9 level after packing", 32'(level), 4);
    chk(stat_view && irq, "R10 flag set at threshold", {30'b0, stat_view, irq}, 32'h3);
    stat_en = 1'b0;
    @(negedge clk);
    chk(!stat_view && irq, "R11 status view gated", {30'b0, stat_view, irq}, 32'h1);
    sig_en = 1'b0;
    @(negedge clk);
    chk(!irq, "R11 irq gated", 32'(irq), 0);
    sig_en = 1'b1; stat_en = 1'b1;
    man_read();
    chk(level == 3 && stat_view, "R10 flag kept at threshold", {25'b0, stat_view, level}, 32'h43);
    man_read();
    chk(level == 2 && !stat_view && !irq, "R10 flag cleared below threshold",
        {24'b0, irq, stat_view, level}, 32'h2);
    mon_en = 1'b1;
    drain();
    mon_en = 1'b0;
    man_read();
    chk(level == '0, "R9 empty read keeps level", 32'(level), 0);
    mon_en = 1'b1;
    stat_thld = 5'd31;

    finish_run();
  end
endmodule